// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a watchdog that software must service through a small word-wide register bus. A down-counter advances once per tick. A tick is a clock-enable pulse that a built-in prescaler produces every `TICK_DIV` clocks. When the count runs out the first time, the block only records the event. It can also raise an SMI request, and it then starts counting again. If the count runs out a second time with no service in between, the block escalates. It records the second timeout and raises a one-cycle system-reset request. The reset request is withheld while the reboot-inhibit strap or the no-reboot configuration input is high. In that case the second expiry behaves like a first one and the timer keeps running.

The register set also holds data-in and data-out bytes for software signalling, two message bytes, a watchdog-count byte, a second control word and a software IRQ byte. A write to data-in raises SMI. A write to data-out sets an interrupt-status flag, and that flag is driven out as a level.

The sequencing is a three-state machine. `WD_IDLE` means the count is stopped. `WD_RUN` means the count is running with no timeout pending. `WD_WARNED` means the count is running after one expiry. The transitions are:
- START (`WD_IDLE`→`WD_RUN`): a reload or control-1 write while the timer may run.
- HALT (`WD_RUN` or `WD_WARNED`→`WD_IDLE`): a control-1 write that forbids running.
- SERVICE (`WD_WARNED`→`WD_RUN`, or `WD_RUN` staying in `WD_RUN`): a reload write.
- FIRST (`WD_RUN`→`WD_WARNED`): an expiry with no timeout pending.
- SECOND_BLOCKED (`WD_WARNED`→`WD_RUN`): a second expiry while the reset is inhibited.
- FIRE (`WD_WARNED`→`WD_IDLE`): a second expiry that requests reset.

Top module: `wdt_top`

## Requirements
- R1: After reset the registers read as follows, and every other register and all three outputs are zero:
  - timer value (offset 1): 0x0004
  - control 2 (offset 3): 0x0008
  - software IRQ (offset 11): 0x0003
  - reload (offset 0): 0x0000, with the count stopped
- R2: The count may run only when control-1 bit 0 (halt) is 0 and the low 10 bits of the timer value are greater than 1. A value of 0 or 1 never starts the count.
- R3: A write to reload (offset 0) discards a pending first timeout. If the timer may run, the stored reload becomes the timer value and counting restarts from its low 10 bits. Otherwise the written word is stored and nothing starts.
- R4: The count expires on the tick that finds it at 1 (or 0). A first expiry does three things: it sets status-1 bit 0, it pulses `smi_req` for one cycle when `smi_en` is high, and it reloads the count and the stored reload from the timer value.
- R5: A second consecutive expiry sets status-2 bits 0 and 1. When both `reboot_strap` and `no_reboot` are low, it also does the following:
  - pulses `sys_rst_req` for one cycle
  - raises no SMI
  - stops the count
  - leaves reload reading 0x0000
- R6: When either inhibit input is high, a second expiry sets the same status-2 bits, raises SMI per `smi_en`, reloads and clears the pending timeout. The next expiry then counts as a first one.
- R7: A control-1 write (offset 2) stores the written word ANDed with 0x0003. Bit 1 (lock) cannot be cleared once set until reset. The count then restarts from the timer value if it may run, and stops otherwise. Stopping discards a pending timeout.
- R8: A data-in write (offset 6) does three things: it stores the low byte, it sets status-1 bit 1, and it pulses `smi_req` whatever `smi_en` is.
- R9: A data-out write (offset 7) stores the low byte and sets status-1 bit 2. The `irq_sts` output equals status-1 bit 2.
- R10: While counting, a reload read returns the remaining count in bits 9:0 and stored-reload bits 15:10 above it. While stopped, it returns the stored reload word.
- R11: A status-1 write (offset 4) stores the word ANDed with 0x0007. A status-2 write (offset 5) stores the word ANDed with 0x0003.
- R12: The following registers are plain storage:
  - control 2, 16 bits
  - message A (offset 8), low byte
  - message B (offset 9), low byte
  - watchdog count (offset 10), low byte
  - software IRQ, low byte
  - timer value, 16 bits

  Writing the timer value leaves the running count unchanged until the next reload.
- R13: A reload or control-1 write in the same cycle as an expiry cancels that expiry: no flag, no SMI, and the write's effect applies. A status write in an expiry cycle stores the written value instead of the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| smi_en | input | 1 | Allows SMI on expiry |
| reboot_strap | input | 1 | Inhibits the reset request when high |
| no_reboot | input | 1 | Inhibits the reset request when high |
| smi_req | output | 1 | One-cycle SMI request |
| irq_sts | output | 1 | Interrupt-status level (status-1 bit 2) |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
A bus write can land in the same clock as an expiry. The bench provokes this by timing a write so that it commits on the exact edge where the count reaches its end. It does this once with a reload write and once with a status-1 write. For the reload case, the outputs must show no SMI, status 1 must stay clear, and the count must be full again. For the status case, the SMI still appears, but status 1 must hold only the written value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_RUN    = 2'd1,
        WD_WARNED = 2'd2
    } wd_state_t;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_TVAL   = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL1  = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_CTRL2  = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_STAT1  = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_STAT2  = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_MSGA   = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_MSGB   = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_WDCNT  = 4'd10;
    localparam logic [ADDR_W-1:0] OFS_SWIRQ  = 4'd11;

    localparam logic [DATA_W-1:0] STAT1_MASK = 16'h0007;
    localparam logic [DATA_W-1:0] STAT2_MASK = 16'h0003;
    localparam logic [DATA_W-1:0] CTRL1_MASK = 16'h0003;

    localparam int C1_HALT = 0;
    localparam int C1_LOCK = 1;
    localparam int S1_TOUT = 0;
    localparam int S1_SWSMI = 1;
    localparam int S1_INTS = 2;

    localparam logic [DATA_W-1:0] TVAL_RST  = 16'h0004;
    localparam logic [DATA_W-1:0] CTRL2_RST = 16'h0008;
    localparam logic [BYTE_W-1:0] SWIRQ_RST = 8'h03;

endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int TV_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            wr_reload,
    input  logic            wr_ctrl1,
    input  logic            start_ok,
    input  logic [TV_W-1:0] tval_f,
    input  logic            smi_en,
    input  logic            reboot_strap,
    input  logic            no_reboot,
    output logic            running,
    output logic [TV_W-1:0] remain,
    output logic            expire,
    output logic            second,
    output logic            fire,
    output logic            exp_smi_q,
    output logic            rst_req_q
);
    wd_state_t state_q, state_d;
    logic [TV_W-1:0] remain_q;
    logic            load;
    logic            svc_wr;

    assign svc_wr  = wr_reload | wr_ctrl1;
    assign running = (state_q != WD_IDLE);
    assign remain  = remain_q;
    assign expire  = running && tick && (remain_q <= TV_W'(1)) && !svc_wr;
    assign second  = expire && (state_q == WD_WARNED);
    assign fire    = second && !reboot_strap && !no_reboot;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (svc_wr && start_ok) begin
                    state_d = WD_RUN;
                    load    = 1'b1;
                end
            end
            WD_RUN: begin
                if (wr_ctrl1) begin
                    state_d = start_ok ? WD_RUN : WD_IDLE;
                    load    = start_ok;
                end else if (wr_reload) begin
                    load    = start_ok;
                end else if (expire) begin
                    state_d = WD_WARNED;
                    load    = 1'b1;
                end
            end
            WD_WARNED: begin
                if (wr_ctrl1) begin
                    state_d = start_ok ? WD_RUN : WD_IDLE;
                    load    = start_ok;
                end else if (wr_reload) begin
                    state_d = WD_RUN;
                    load    = start_ok;
                end else if (expire) begin
                    state_d = fire ? WD_IDLE : WD_RUN;
                    load    = !fire;
                end
            end
            default: begin
                state_d = WD_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WD_IDLE;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                remain_q <= tval_f;
            end else if (running && tick && remain_q > TV_W'(1)) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_smi_q <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            exp_smi_q <= expire && !fire && smi_en;
            rst_req_q <= fire;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int TV_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              running,
    input  logic [TV_W-1:0]   remain,
    input  logic              expire,
    input  logic              second,
    input  logic              fire,
    output logic              wr_reload,
    output logic              wr_ctrl1,
    output logic              wr_stat2,
    output logic              start_ok,
    output logic [TV_W-1:0]   tval_f,
    output logic [DATA_W-1:0] ctrl1_q,
    output logic [DATA_W-1:0] stat1_q,
    output logic [DATA_W-1:0] stat2_q,
    output logic              din_smi_q
);
    logic [DATA_W-1:0] rld_q, tval_q, ctrl2_q, ctrl1_new;
    logic [BYTE_W-1:0] din_q, dout_q, msga_q, msgb_q, wdcnt_q, swirq_q;
    logic wr_stat1, wr_din, wr_dout;
    logic [DATA_W-1:0] s1_set;

    assign wr_reload = bus_wr && (bus_addr == OFS_RELOAD);
    assign wr_ctrl1  = bus_wr && (bus_addr == OFS_CTRL1);
    assign wr_stat1  = bus_wr && (bus_addr == OFS_STAT1);
    assign wr_stat2  = bus_wr && (bus_addr == OFS_STAT2);
    assign wr_din    = bus_wr && (bus_addr == OFS_DIN);
    assign wr_dout   = bus_wr && (bus_addr == OFS_DOUT);

    assign tval_f    = tval_q[TV_W-1:0];
    assign ctrl1_new = (bus_wdata & CTRL1_MASK) | (ctrl1_q & (DATA_W'(1) << C1_LOCK));

    always_comb begin
        if (wr_ctrl1) begin
            start_ok = !ctrl1_new[C1_HALT] && (tval_f > TV_W'(1));
        end else begin
            start_ok = !ctrl1_q[C1_HALT] && (tval_f > TV_W'(1));
        end
    end

    always_comb begin
        s1_set = '0;
        s1_set[S1_TOUT]  = expire;
        s1_set[S1_SWSMI] = wr_din;
        s1_set[S1_INTS]  = wr_dout;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q     <= '0;
            tval_q    <= TVAL_RST;
            ctrl1_q   <= '0;
            ctrl2_q   <= CTRL2_RST;
            stat1_q   <= '0;
            stat2_q   <= '0;
            din_q     <= '0;
            dout_q    <= '0;
            msga_q    <= '0;
            msgb_q    <= '0;
            wdcnt_q   <= '0;
            swirq_q   <= SWIRQ_RST;
            din_smi_q <= 1'b0;
        end else begin
            din_smi_q <= wr_din;

            if (wr_reload) begin
                rld_q <= start_ok ? tval_q : bus_wdata;
            end else if (wr_ctrl1 && start_ok) begin
                rld_q <= tval_q;
            end else if (expire) begin
                rld_q <= fire ? '0 : tval_q;
            end

            if (wr_stat1) begin
                stat1_q <= bus_wdata & STAT1_MASK;
            end else begin
                stat1_q <= stat1_q | s1_set;
            end

            if (wr_stat2) begin
                stat2_q <= bus_wdata & STAT2_MASK;
            end else if (second) begin
                stat2_q <= stat2_q | STAT2_MASK;
            end

            if (wr_ctrl1) begin
                ctrl1_q <= ctrl1_new;
            end

            if (bus_wr) begin
                unique case (bus_addr)
                    OFS_TVAL:  tval_q  <= bus_wdata;
                    OFS_CTRL2: ctrl2_q <= bus_wdata;
                    OFS_DIN:   din_q   <= bus_wdata[BYTE_W-1:0];
                    OFS_DOUT:  dout_q  <= bus_wdata[BYTE_W-1:0];
                    OFS_MSGA:  msga_q  <= bus_wdata[BYTE_W-1:0];
                    OFS_MSGB:  msgb_q  <= bus_wdata[BYTE_W-1:0];
                    OFS_WDCNT: wdcnt_q <= bus_wdata[BYTE_W-1:0];
                    OFS_SWIRQ: swirq_q <= bus_wdata[BYTE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_RELOAD: bus_rdata = running ? {rld_q[DATA_W-1:TV_W], remain} : rld_q;
            OFS_TVAL:   bus_rdata = tval_q;
            OFS_CTRL1:  bus_rdata = ctrl1_q;
            OFS_CTRL2:  bus_rdata = ctrl2_q;
            OFS_STAT1:  bus_rdata = stat1_q;
            OFS_STAT2:  bus_rdata = stat2_q;
            OFS_DIN:    bus_rdata = DATA_W'(din_q);
            OFS_DOUT:   bus_rdata = DATA_W'(dout_q);
            OFS_MSGA:   bus_rdata = DATA_W'(msga_q);
            OFS_MSGB:   bus_rdata = DATA_W'(msgb_q);
            OFS_WDCNT:  bus_rdata = DATA_W'(wdcnt_q);
            OFS_SWIRQ:  bus_rdata = DATA_W'(swirq_q);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int TICK_DIV = 1000,
    parameter int TV_W     = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        smi_en,
    input  logic        reboot_strap,
    input  logic        no_reboot,
    output logic        smi_req,
    output logic        irq_sts,
    output logic        sys_rst_req
);
    logic tick, running, expire, second, fire;
    logic wr_reload, wr_ctrl1, wr_stat2, start_ok;
    logic exp_smi_q, din_smi_q;
    logic [TV_W-1:0] remain, tval_f;
    logic [DATA_W-1:0] ctrl1_q, stat1_q, stat2_q;

    wdt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    wdt_regs #(.TV_W(TV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .running   (running),
        .remain    (remain),
        .expire    (expire),
        .second    (second),
        .fire      (fire),
        .wr_reload (wr_reload),
        .wr_ctrl1  (wr_ctrl1),
        .wr_stat2  (wr_stat2),
        .start_ok  (start_ok),
        .tval_f    (tval_f),
        .ctrl1_q   (ctrl1_q),
        .stat1_q   (stat1_q),
        .stat2_q   (stat2_q),
        .din_smi_q (din_smi_q)
    );

    wdt_fsm #(.TV_W(TV_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .wr_reload    (wr_reload),
        .wr_ctrl1     (wr_ctrl1),
        .start_ok     (start_ok),
        .tval_f       (tval_f),
        .smi_en       (smi_en),
        .reboot_strap (reboot_strap),
        .no_reboot    (no_reboot),
        .running      (running),
        .remain       (remain),
        .expire       (expire),
        .second       (second),
        .fire         (fire),
        .exp_smi_q    (exp_smi_q),
        .rst_req_q    (sys_rst_req)
    );

    assign smi_req = exp_smi_q | din_smi_q;
    assign irq_sts = stat1_q[S1_INTS];
endmodule

// File: rtl/wdt_check.sv
module wdt_check #(
    parameter int TV_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sys_rst_req,
    input logic            reboot_strap,
    input logic            no_reboot,
    input logic            running,
    input logic            lock,
    input logic [TV_W-1:0] tval_f,
    input logic [1:0]      stat2_lo,
    input logic            wr_stat2
);
    assert_rst_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(!reboot_strap && !no_reboot));

    assert_rst_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> !running);

    assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    assert_rst_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req && !$past(wr_stat2)) |-> (stat2_lo == 2'b11));

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    assert_no_short_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(tval_f) > TV_W'(1)));
endmodule

bind wdt_top wdt_check #(.TV_W(TV_W)) u_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_rst_req  (sys_rst_req),
    .reboot_strap (reboot_strap),
    .no_reboot    (no_reboot),
    .running      (running),
    .lock         (ctrl1_q[1]),
    .tval_f       (tval_f),
    .stat2_lo     (stat2_q[1:0]),
    .wr_stat2     (wr_stat2)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        smi_en = 1'b0;
    logic        reboot_strap = 1'b0;
    logic        no_reboot = 1'b0;
    logic        smi_req, irq_sts, sys_rst_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_RLD = 4'd0, A_TVAL = 4'd1, A_C1 = 4'd2, A_C2 = 4'd3,
                           A_S1 = 4'd4, A_S2 = 4'd5, A_DIN = 4'd6, A_DOUT = 4'd7,
                           A_MA = 4'd8, A_MB = 4'd9, A_WC = 4'd10, A_SW = 4'd11;

    always #4 clk = ~clk;

    wdt_top #(.TICK_DIV(1)) dut (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .smi_en (smi_en),
        .reboot_strap (reboot_strap), .no_reboot (no_reboot),
        .smi_req (smi_req), .irq_sts (irq_sts), .sys_rst_req (sys_rst_req)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        smi_en = 1'b0; reboot_strap = 1'b0; no_reboot = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        rd(A_TVAL, d); check("R1 tval", d, 16'h0004);
        rd(A_C2, d);   check("R1 ctrl2", d, 16'h0008);
        rd(A_SW, d);   check("R1 swirq", d, 16'h0003);
        rd(A_RLD, d);  check("R1 reload", d, 16'h0000);
        rd(A_C1, d);   check("R1 ctrl1", d, 16'h0000);
        rd(A_S1, d);   check("R1 stat1", d, 16'h0000);
        check("R1 outputs", {13'd0, smi_req, irq_sts, sys_rst_req}, 16'h0000);
        smi_en = 1'b1;
        repeat (8) @(negedge clk);
        check("R1 stopped no smi", {15'd0, smi_req}, 16'h0000);
    endtask

    task automatic t_no_start();
        logic [15:0] d;
        bit seen;
        do_reset();
        smi_en = 1'b1;
        for (int v = 0; v < 2; v++) begin
            wr(A_TVAL, 16'(v));
            wr(A_RLD, 16'h1234);
            rd(A_RLD, d); check("R2 R3 stored reload", d, 16'h1234);
            seen = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (smi_req) seen = 1'b1;
            end
            check("R2 no start", {15'd0, seen}, 16'h0000);
        end
    endtask

    task automatic t_escalate_blocked();
        logic [15:0] d;
        do_reset();
        smi_en = 1'b1; reboot_strap = 1'b1;
        @(negedge clk);
        wr(A_TVAL, 16'hFC05);
        wr(A_RLD, 16'h0000);
        rd(A_RLD, d); check("R10 running read", d, 16'hFC05);
        repeat (2) @(negedge clk);
        rd(A_RLD, d); check("R10 remaining", d, 16'hFC03);
        repeat (2) @(negedge clk);
        check("R4 no early smi", {15'd0, smi_req}, 16'h0000);
        @(negedge clk);
        check("R4 first smi", {15'd0, smi_req}, 16'h0001);
        rd(A_S1, d); check("R4 timeout flag", d, 16'h0001);
        rd(A_RLD, d); check("R4 reloaded", d, 16'hFC05);
        @(negedge clk);
        check("R4 smi pulse", {15'd0, smi_req}, 16'h0000);
        repeat (4) @(negedge clk);
        check("R6 smi second", {15'd0, smi_req}, 16'h0001);
        check("R6 no reset", {15'd0, sys_rst_req}, 16'h0000);
        rd(A_S2, d); check("R6 stat2 flags", d, 16'h0003);
        reboot_strap = 1'b0;
        repeat (5) @(negedge clk);
        check("R6 counter cleared", {14'd0, smi_req, sys_rst_req}, 16'h0002);
        repeat (5) @(negedge clk);
        check("R5 reset req", {14'd0, smi_req, sys_rst_req}, 16'h0001);
        @(negedge clk);
        check("R5 reset pulse", {15'd0, sys_rst_req}, 16'h0000);
        rd(A_RLD, d); check("R5 reload zero", d, 16'h0000);
    endtask

    task automatic t_fire();
        logic [15:0] d;
        bit seen;
        do_reset();
        smi_en = 1'b1;
        @(negedge clk);
        wr(A_TVAL, 16'h0003);
        wr(A_RLD, 16'h0000);
        repeat (3) @(negedge clk);
        check("R4 smi", {14'd0, smi_req, sys_rst_req}, 16'h0002);
        repeat (3) @(negedge clk);
        check("R5 fire no smi", {14'd0, smi_req, sys_rst_req}, 16'h0001);
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (smi_req || sys_rst_req) seen = 1'b1;
        end
        check("R5 stopped", {15'd0, seen}, 16'h0000);
        do_reset();
        no_reboot = 1'b1;
        @(negedge clk);
        wr(A_TVAL, 16'h0002);
        wr(A_RLD, 16'h0000);
        repeat (2) @(negedge clk);
        check("R4 smi_en low", {15'd0, smi_req}, 16'h0000);
        rd(A_S1, d); check("R4 flag", d, 16'h0001);
        repeat (2) @(negedge clk);
        check("R6 no_reboot blocks", {15'd0, sys_rst_req}, 16'h0000);
        rd(A_S2, d); check("R6 flags", d, 16'h0003);
    endtask

    task automatic t_reload_clears();
        do_reset();
        smi_en = 1'b1;
        @(negedge clk);
        wr(A_RLD, 16'h0000);
        repeat (4) @(negedge clk);
        check("R3 first", {14'd0, smi_req, sys_rst_req}, 16'h0002);
        @(negedge clk);
        wr(A_RLD, 16'h0000);
        repeat (4) @(negedge clk);
        check("R3 service cleared", {14'd0, smi_req, sys_rst_req}, 16'h0002);
        repeat (4) @(negedge clk);
        check("R3 then reset", {15'd0, sys_rst_req}, 16'h0001);
    endtask

    task automatic t_ctrl1();
        logic [15:0] d;
        do_reset();
        smi_en = 1'b1;
        @(negedge clk);
        wr(A_C1, 16'hFFFF);
        rd(A_C1, d); check("R7 masked", d, 16'h0003);
        repeat (6) @(negedge clk);
        check("R7 halted", {15'd0, smi_req}, 16'h0000);
        wr(A_C1, 16'h0000);
        rd(A_C1, d); check("R7 lock sticky", d, 16'h0002);
        rd(A_RLD, d); check("R7 restart", d, 16'h0004);
        @(negedge clk);
        rd(A_RLD, d); check("R7 counting", d, 16'h0003);
        wr(A_C1, 16'h0001);
        rd(A_RLD, d); check("R7 stop", d, 16'h0004);
    endtask

    task automatic t_din_dout();
        logic [15:0] d;
        do_reset();
        @(negedge clk);
        wr(A_DIN, 16'h01AB);
        check("R8 smi", {15'd0, smi_req}, 16'h0001);
        rd(A_DIN, d); check("R8 byte", d, 16'h00AB);
        rd(A_S1, d);  check("R8 flag", d, 16'h0002);
        @(negedge clk);
        check("R8 pulse", {15'd0, smi_req}, 16'h0000);
        check("R9 irq low", {15'd0, irq_sts}, 16'h0000);
        wr(A_DOUT, 16'h03CD);
        rd(A_DOUT, d); check("R9 byte", d, 16'h00CD);
        rd(A_S1, d);   check("R9 flag", d, 16'h0006);
        check("R9 irq", {15'd0, irq_sts}, 16'h0001);
    endtask

    task automatic t_stat_mask();
        logic [15:0] d;
        do_reset();
        @(negedge clk);
        wr(A_S1, 16'hFFFF);
        rd(A_S1, d); check("R11 stat1", d, 16'h0007);
        check("R11 R9 irq", {15'd0, irq_sts}, 16'h0001);
        wr(A_S1, 16'h0000);
        check("R11 irq clr", {15'd0, irq_sts}, 16'h0000);
        wr(A_S2, 16'hFFFF);
        rd(A_S2, d); check("R11 stat2", d, 16'h0003);
    endtask

    task automatic t_plain();
        logic [15:0] d;
        do_reset();
        smi_en = 1'b1; reboot_strap = 1'b1;
        @(negedge clk);
        wr(A_C2, 16'hA5A5); rd(A_C2, d); check("R12 ctrl2", d, 16'hA5A5);
        wr(A_MA, 16'h01FF); rd(A_MA, d); check("R12 msgA", d, 16'h00FF);
        wr(A_MB, 16'h0042); rd(A_MB, d); check("R12 msgB", d, 16'h0042);
        wr(A_WC, 16'h5566); rd(A_WC, d); check("R12 wdcnt", d, 16'h0066);
        wr(A_SW, 16'h1234); rd(A_SW, d); check("R12 swirq", d, 16'h0034);
        wr(A_TVAL, 16'h0006);
        wr(A_RLD, 16'h0000);
        repeat (2) @(negedge clk);
        wr(A_TVAL, 16'h0009);
        rd(A_RLD, d); check("R12 count kept", d, 16'h0003);
        repeat (3) @(negedge clk);
        check("R12 expiry old", {15'd0, smi_req}, 16'h0001);
        rd(A_RLD, d); check("R12 new value", d, 16'h0009);
    endtask

    task automatic t_collide();
        logic [15:0] d;
        do_reset();
        smi_en = 1'b1; reboot_strap = 1'b1;
        @(negedge clk);
        wr(A_RLD, 16'h0000);
        repeat (3) @(negedge clk);
        wr(A_RLD, 16'h0000);
        check("R13 reload cancels", {15'd0, smi_req}, 16'h0000);
        rd(A_S1, d);  check("R13 no flag", d, 16'h0000);
        rd(A_RLD, d); check("R13 full count", d, 16'h0004);
        repeat (3) @(negedge clk);
        wr(A_S1, 16'h0004);
        check("R13 expiry smi", {15'd0, smi_req}, 16'h0001);
        rd(A_S1, d); check("R13 write wins", d, 16'h0004);
    endtask

    initial begin
        t_reset();
        t_no_start();
        t_escalate_blocked();
        t_fire();
        t_reload_clears();
        t_ctrl1();
        t_din_dout();
        t_stat_mask();
        t_plain();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule